// File: doc/BRIEF.md
# Crossbar Response Return Router

This block carries the slave-to-master half of a multi-master, multi-slave on-chip crossbar. It covers two return channels: read data and write response. Each slave port has a one-hot master-select vector, which the per-slave arbiter produces. Using that vector, the router sends the slave's read beat (data, response code, last flag, valid) and its write response (code, valid) to the one master that holds the grant. The master's read-ready and response-ready signals go back only to that slave. A master that holds no grant sees all-zero buses.

One extra slave slot, at the highest index, is reserved for the default (error) slave. That slave answers accesses to unmapped addresses. The router also produces registered per-slave completion pulses. A read-end pulse marks the accepted final beat of a read burst, and a write-end pulse marks an accepted write response. The arbiter of that slave uses these pulses to release its grant. Arbitration, address decoding and reordering happen elsewhere.

Top module: `resp_return_router`

## Requirements
- R1: When bit m of slave s's select field `slv_grant[s*NUM_MST+m]` is 1, master m's `m_rdata`, `m_rresp`, `m_rlast` and `m_rvalid` equal slave s's read signals in the same cycle. Slave index NUM_SLV is the default slave.
- R2: A master whose bit is 0 in every slave's select field sees zero on all of its read and write-response outputs.
- R3: `s_rready[s]` is the OR of `m_rready[m]` over the masters selected in slave s's field. It is 0 when no master is selected or the selected master is not ready.
- R4: `s_bready[s]` follows the same steering rule using `m_bready`.
- R5: A selected master's `m_bresp` and `m_bvalid` equal the write-response signals of its slave in the same cycle.
- R6: `rd_end[s]` is 1 exactly one clock after a cycle in which `s_rvalid[s]`, `s_rlast[s]` and `s_rready[s]` are all 1. A handshake on a non-final beat produces no pulse.
- R7: `wr_end[s]` is 1 exactly one clock after a cycle in which `s_bvalid[s]` and `s_bready[s]` are both 1.
- R8: A valid raised by a slave that has not selected a master reaches no master and causes no end pulse at that slave.
- R9: Response codes pass through unchanged: 2'b00 OKAY, 2'b01 EXOKAY, 2'b10 SLVERR, 2'b11 DECERR.
- R10: While `rst_n` is 0, and in the first cycle after it rises, `rd_end` and `wr_end` are all zero.
- R11: Several masters can each receive from a different slave in the same cycle, each on its own path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slv_grant | input | (NUM_SLV+1)*NUM_MST | Per-slave one-hot master select, slave s at bits [s*NUM_MST +: NUM_MST] |
| s_rdata | input | (NUM_SLV+1)*DATA_W | Read data from each slave |
| s_rresp | input | (NUM_SLV+1)*2 | Read response code from each slave |
| s_rlast | input | NUM_SLV+1 | Final-beat flag from each slave |
| s_rvalid | input | NUM_SLV+1 | Read valid from each slave |
| s_rready | output | NUM_SLV+1 | Read ready steered to each slave |
| s_bresp | input | (NUM_SLV+1)*2 | Write response code from each slave |
| s_bvalid | input | NUM_SLV+1 | Write response valid from each slave |
| s_bready | output | NUM_SLV+1 | Response ready steered to each slave |
| m_rready | input | NUM_MST | Read ready from each master |
| m_bready | input | NUM_MST | Response ready from each master |
| m_rdata | output | NUM_MST*DATA_W | Read data to each master |
| m_rresp | output | NUM_MST*2 | Read response code to each master |
| m_rlast | output | NUM_MST | Final-beat flag to each master |
| m_rvalid | output | NUM_MST | Read valid to each master |
| m_bresp | output | NUM_MST*2 | Write response code to each master |
| m_bvalid | output | NUM_MST | Write response valid to each master |
| rd_end | output | NUM_SLV+1 | One-cycle read-completion pulse per slave |
| wr_end | output | NUM_SLV+1 | One-cycle write-completion pulse per slave |

## Verification
The bench builds the router with four masters, four mapped slaves plus the default slot, and a 16-bit data bus. It sweeps every one of the twenty single master-slave pairings and checks, in one pass, routing, zeroing of idle masters, ready steering and both end pulses. Five rotating permutations then drive four masters from distinct slaves at once, with one slave left unselected, so every slave index (the default slot included) gets tested both selected and stray. The slave response codes cover all four encodings.

// File: rtl/rrr_pkg.sv
package rrr_pkg;
  localparam int RESP_W = 2;

  typedef enum logic [RESP_W-1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } resp_code_e;

  // Final read beat accepted at a slave port
  function automatic logic burst_closes(input logic vld, input logic lst, input logic rdy);
    return vld & lst & rdy;
  endfunction

  // Write response accepted at a slave port
  function automatic logic resp_taken(input logic vld, input logic rdy);
    return vld & rdy;
  endfunction
endpackage

// File: rtl/rrr_master_mux.sv
module rrr_master_mux #(
  parameter int NSL = 5,
  parameter int DW  = 64
) (
  input  logic [NSL-1:0]    pick,
  input  logic [NSL*DW-1:0] s_rdata,
  input  logic [NSL*2-1:0]  s_rresp,
  input  logic [NSL-1:0]    s_rlast,
  input  logic [NSL-1:0]    s_rvalid,
  input  logic [NSL*2-1:0]  s_bresp,
  input  logic [NSL-1:0]    s_bvalid,
  output logic [DW-1:0]     m_rdata,
  output logic [1:0]        m_rresp,
  output logic              m_rlast,
  output logic              m_rvalid,
  output logic [1:0]        m_bresp,
  output logic              m_bvalid
);
  // AND-OR selection: an unpicked slave contributes zero
  always_comb begin
    m_rdata  = '0;
    m_rresp  = '0;
    m_rlast  = 1'b0;
    m_rvalid = 1'b0;
    m_bresp  = '0;
    m_bvalid = 1'b0;
    for (int s = 0; s < NSL; s++) begin
      if (pick[s]) begin
        m_rdata  = m_rdata  | s_rdata[s*DW +: DW];
        m_rresp  = m_rresp  | s_rresp[s*2 +: 2];
        m_rlast  = m_rlast  | s_rlast[s];
        m_rvalid = m_rvalid | s_rvalid[s];
        m_bresp  = m_bresp  | s_bresp[s*2 +: 2];
        m_bvalid = m_bvalid | s_bvalid[s];
      end
    end
  end
endmodule

// File: rtl/rrr_ready_steer.sv
module rrr_ready_steer #(
  parameter int NM = 4
) (
  input  logic [NM-1:0] grant,
  input  logic [NM-1:0] m_rready,
  input  logic [NM-1:0] m_bready,
  output logic          s_rready,
  output logic          s_bready
);
  assign s_rready = |(grant & m_rready);
  assign s_bready = |(grant & m_bready);
endmodule

// File: rtl/rrr_end_pulse.sv
module rrr_end_pulse
  import rrr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_final_hs,
  input  logic wr_resp_hs,
  output logic rd_end,
  output logic wr_end
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_end <= 1'b0;
      wr_end <= 1'b0;
    end else begin
      rd_end <= rd_final_hs;
      wr_end <= wr_resp_hs;
    end
  end
endmodule

// File: rtl/resp_return_router.sv
module resp_return_router
  import rrr_pkg::*;
#(
  parameter int NUM_MST = 4,
  parameter int NUM_SLV = 4,
  parameter int DATA_W  = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [(NUM_SLV+1)*NUM_MST-1:0] slv_grant,
  input  logic [(NUM_SLV+1)*DATA_W-1:0]  s_rdata,
  input  logic [(NUM_SLV+1)*2-1:0]       s_rresp,
  input  logic [NUM_SLV:0]               s_rlast,
  input  logic [NUM_SLV:0]               s_rvalid,
  output logic [NUM_SLV:0]               s_rready,
  input  logic [(NUM_SLV+1)*2-1:0]       s_bresp,
  input  logic [NUM_SLV:0]               s_bvalid,
  output logic [NUM_SLV:0]               s_bready,
  input  logic [NUM_MST-1:0]             m_rready,
  input  logic [NUM_MST-1:0]             m_bready,
  output logic [NUM_MST*DATA_W-1:0]      m_rdata,
  output logic [NUM_MST*2-1:0]           m_rresp,
  output logic [NUM_MST-1:0]             m_rlast,
  output logic [NUM_MST-1:0]             m_rvalid,
  output logic [NUM_MST*2-1:0]           m_bresp,
  output logic [NUM_MST-1:0]             m_bvalid,
  output logic [NUM_SLV:0]               rd_end,
  output logic [NUM_SLV:0]               wr_end
);
  localparam int NSL = NUM_SLV + 1;  // mapped slaves plus default slot

  // Named internal events
  logic [NSL-1:0]              rd_final_hs;
  logic [NSL-1:0]              wr_resp_hs;
  logic [NUM_MST-1:0][NSL-1:0] pick_col;

  // Per-slave ready steering and completion pulses
  for (genvar s = 0; s < NSL; s++) begin : g_slv
    rrr_ready_steer #(.NM(NUM_MST)) u_steer (
      .grant    (slv_grant[s*NUM_MST +: NUM_MST]),
      .m_rready (m_rready),
      .m_bready (m_bready),
      .s_rready (s_rready[s]),
      .s_bready (s_bready[s])
    );

    assign rd_final_hs[s] = burst_closes(s_rvalid[s], s_rlast[s], s_rready[s]);
    assign wr_resp_hs[s]  = resp_taken(s_bvalid[s], s_bready[s]);

    rrr_end_pulse u_end (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_final_hs (rd_final_hs[s]),
      .wr_resp_hs  (wr_resp_hs[s]),
      .rd_end      (rd_end[s]),
      .wr_end      (wr_end[s])
    );
  end

  // Per-master return multiplexers
  for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
    for (genvar s = 0; s < NSL; s++) begin : g_col
      assign pick_col[m][s] = slv_grant[s*NUM_MST + m];
    end

    rrr_master_mux #(.NSL(NSL), .DW(DATA_W)) u_mux (
      .pick     (pick_col[m]),
      .s_rdata  (s_rdata),
      .s_rresp  (s_rresp),
      .s_rlast  (s_rlast),
      .s_rvalid (s_rvalid),
      .s_bresp  (s_bresp),
      .s_bvalid (s_bvalid),
      .m_rdata  (m_rdata[m*DATA_W +: DATA_W]),
      .m_rresp  (m_rresp[m*2 +: 2]),
      .m_rlast  (m_rlast[m]),
      .m_rvalid (m_rvalid[m]),
      .m_bresp  (m_bresp[m*2 +: 2]),
      .m_bvalid (m_bvalid[m])
    );
  end
endmodule

// File: rtl/rrr_checker.sv
module rrr_checker #(
  parameter int NUM_MST = 4,
  parameter int NUM_SLV = 4,
  parameter int DATA_W  = 64
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [(NUM_SLV+1)*NUM_MST-1:0] slv_grant,
  input logic [NUM_SLV:0]               s_rlast,
  input logic [NUM_SLV:0]               s_rvalid,
  input logic [NUM_SLV:0]               s_rready,
  input logic [NUM_SLV:0]               s_bvalid,
  input logic [NUM_SLV:0]               s_bready,
  input logic [NUM_MST*DATA_W-1:0]      m_rdata,
  input logic [NUM_MST-1:0]             m_rvalid,
  input logic [NUM_MST-1:0]             m_bvalid,
  input logic [NUM_SLV:0]               rd_end,
  input logic [NUM_SLV:0]               wr_end
);
  localparam int NSL = NUM_SLV + 1;

  logic [NUM_MST-1:0] mst_idle;
  logic [NUM_MST-1:0] mst_r_src;
  logic [NUM_MST-1:0] mst_b_src;

  always_comb begin
    mst_idle  = '1;
    mst_r_src = '0;
    mst_b_src = '0;
    for (int m = 0; m < NUM_MST; m++) begin
      for (int s = 0; s < NSL; s++) begin
        if (slv_grant[s*NUM_MST + m]) begin
          mst_idle[m]  = 1'b0;
          mst_r_src[m] = mst_r_src[m] | s_rvalid[s];
          mst_b_src[m] = mst_b_src[m] | s_bvalid[s];
        end
      end
    end
  end

  for (genvar s = 0; s < NSL; s++) begin : g_s
    AST_UNGRANTED_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (slv_grant[s*NUM_MST +: NUM_MST] == '0) |-> (!s_rready[s] && !s_bready[s])); // R3
    AST_RD_END_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_end[s] |-> $past(s_rvalid[s] && s_rlast[s] && s_rready[s])); // R6
    AST_WR_END_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_end[s] |-> $past(s_bvalid[s] && s_bready[s])); // R7
  end

  for (genvar m = 0; m < NUM_MST; m++) begin : g_m
    AST_IDLE_MASTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      mst_idle[m] |-> (m_rdata[m*DATA_W +: DATA_W] == '0 && !m_rvalid[m] && !m_bvalid[m])); // R2
    AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
      m_rvalid[m] |-> mst_r_src[m]); // R8
    AST_NO_STRAY_BVALID: assert property (@(posedge clk) disable iff (!rst_n)
      m_bvalid[m] |-> mst_b_src[m]); // R8
  end
endmodule

bind resp_return_router rrr_checker #(
  .NUM_MST(NUM_MST), .NUM_SLV(NUM_SLV), .DATA_W(DATA_W)
) u_rrr_checker (
  .clk(clk), .rst_n(rst_n), .slv_grant(slv_grant),
  .s_rlast(s_rlast), .s_rvalid(s_rvalid), .s_rready(s_rready),
  .s_bvalid(s_bvalid), .s_bready(s_bready),
  .m_rdata(m_rdata), .m_rvalid(m_rvalid), .m_bvalid(m_bvalid),
  .rd_end(rd_end), .wr_end(wr_end)
);

// File: tb/tb_resp_return_router.sv
module tb_resp_return_router;
  import rrr_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NM  = 4;
  localparam int NS  = 4;
  localparam int NSL = NS + 1;
  localparam int DW  = 16;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NSL*NM-1:0]    slv_grant = '0;
  logic [NSL*DW-1:0]    s_rdata;
  logic [NSL*2-1:0]     s_rresp;
  logic [NSL-1:0]       s_rlast = '0;
  logic [NSL-1:0]       s_rvalid = '0;
  logic [NSL-1:0]       s_rready;
  logic [NSL*2-1:0]     s_bresp;
  logic [NSL-1:0]       s_bvalid = '0;
  logic [NSL-1:0]       s_bready;
  logic [NM-1:0]        m_rready = '0;
  logic [NM-1:0]        m_bready = '0;
  logic [NM*DW-1:0]     m_rdata;
  logic [NM*2-1:0]      m_rresp;
  logic [NM-1:0]        m_rlast;
  logic [NM-1:0]        m_rvalid;
  logic [NM*2-1:0]      m_bresp;
  logic [NM-1:0]        m_bvalid;
  logic [NSL-1:0]       rd_end;
  logic [NSL-1:0]       wr_end;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resp_return_router #(.NUM_MST(NM), .NUM_SLV(NS), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .slv_grant(slv_grant),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rlast(s_rlast), .s_rvalid(s_rvalid),
    .s_rready(s_rready), .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .m_rready(m_rready), .m_bready(m_bready), .m_rdata(m_rdata), .m_rresp(m_rresp),
    .m_rlast(m_rlast), .m_rvalid(m_rvalid), .m_bresp(m_bresp), .m_bvalid(m_bvalid),
    .rd_end(rd_end), .wr_end(wr_end)
  );

  // Distinct per-slave values; the default slot answers DECERR
  function automatic logic [DW-1:0] exp_data(int s);
    return DW'((s + 1) * 16'h1111 + 16'h0100);
  endfunction
  function automatic logic [1:0] exp_rresp(int s);
    return (s == NS) ? 2'(RESP_DECERR) : 2'(s % 4);
  endfunction
  function automatic logic [1:0] exp_bresp(int s);
    return (s == NS) ? 2'(RESP_DECERR) : 2'(3 - (s % 4));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Check master m against slave s (s<0 means idle)
  task automatic chk_master(int m, int s);
    logic [DW-1:0] d;
    d = m_rdata[m*DW +: DW];
    if (s < 0) begin
      chk(d == '0 && m_rresp[m*2 +: 2] == '0 && !m_rlast[m] && !m_rvalid[m]
          && m_bresp[m*2 +: 2] == '0 && !m_bvalid[m], "R2 idle master zero",
          {d, m_rresp[m*2 +: 2], m_bresp[m*2 +: 2], m_rlast[m], m_rvalid[m], m_bvalid[m]}, 64'h0);
    end else begin
      chk(d == exp_data(s) && m_rlast[m] == s_rlast[s] && m_rvalid[m] == s_rvalid[s],
          "R1 read routing", {d, m_rlast[m], m_rvalid[m]}, {exp_data(s), s_rlast[s], s_rvalid[s]});
      chk(m_rresp[m*2 +: 2] == exp_rresp(s), "R9 rresp code", m_rresp[m*2 +: 2], exp_rresp(s));
      chk(m_bresp[m*2 +: 2] == exp_bresp(s) && m_bvalid[m] == s_bvalid[s], "R5 write response routing",
          {m_bresp[m*2 +: 2], m_bvalid[m]}, {exp_bresp(s), s_bvalid[s]});
    end
  endtask

  initial begin
    for (int s = 0; s < NSL; s++) begin
      s_rdata[s*DW +: DW] = exp_data(s);
      s_rresp[s*2 +: 2]   = exp_rresp(s);
      s_bresp[s*2 +: 2]   = exp_bresp(s);
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    // Reset state (R10): valids and readies high but no grant
    s_rvalid = '1; s_rlast = '1; s_bvalid = '1; m_rready = '1; m_bready = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rd_end == '0 && wr_end == '0, "R10 pulses quiet in reset", {rd_end, wr_end}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(rd_end == '0 && wr_end == '0, "R10 first cycle after reset", {rd_end, wr_end}, 0);
    for (int m = 0; m < NM; m++) chk_master(m, -1);
    chk(s_rready == '0 && s_bready == '0, "R8 ungranted slaves get no ready", {s_rready, s_bready}, 0);
    @(posedge clk); #1;
    chk(rd_end == '0 && wr_end == '0, "R8 stray valid no end pulse", {rd_end, wr_end}, 0);

    // Sweep of every single pairing
    for (int s = 0; s < NSL; s++) begin
      for (int m = 0; m < NM; m++) begin
        @(negedge clk);
        slv_grant = '0; slv_grant[s*NM + m] = 1'b1;
        s_rvalid = '1; s_rlast = '1; s_bvalid = '1; m_rready = '1; m_bready = '1;
        #1;
        for (int k = 0; k < NM; k++) chk_master(k, (k == m) ? s : -1);
        chk(s_rready == NSL'(1 << s), "R3 rready steered", s_rready, NSL'(1 << s));
        chk(s_bready == NSL'(1 << s), "R4 bready steered", s_bready, NSL'(1 << s));
        @(posedge clk); #1;
        chk(rd_end == NSL'(1 << s), "R6 read end pulse", rd_end, NSL'(1 << s));
        chk(wr_end == NSL'(1 << s), "R7 write end pulse", wr_end, NSL'(1 << s));

        // Non-final beat, response not yet taken
        @(negedge clk);
        s_rlast = '0; m_bready = '0;
        #1;
        chk(s_bready == '0, "R4 bready low when master not ready", s_bready, 0);
        @(posedge clk); #1;
        chk(rd_end == '0, "R6 no pulse on non-final beat", rd_end, 0);
        chk(wr_end == '0, "R7 no pulse without bready", wr_end, 0);

        // Only other masters ready
        @(negedge clk);
        s_rlast = '1; m_rready = ~NM'(1 << m); m_bready = ~NM'(1 << m);
        #1;
        chk(s_rready == '0 && s_bready == '0, "R3 other masters ready not steered",
            {s_rready, s_bready}, 0);
        @(posedge clk); #1;
        chk(rd_end == '0 && wr_end == '0, "R8 no end from ungranted ready", {rd_end, wr_end}, 0);
      end
    end

    // Concurrent permutations: master m takes slave (m+k)%NSL
    for (int k = 0; k < NSL; k++) begin
      logic [NSL-1:0] used;
      @(negedge clk);
      slv_grant = '0; used = '0;
      for (int m = 0; m < NM; m++) begin
        slv_grant[((m + k) % NSL)*NM + m] = 1'b1;
        used[(m + k) % NSL] = 1'b1;
      end
      s_rvalid = '1; s_rlast = '1; s_bvalid = '1; m_rready = '1; m_bready = '1;
      #1;
      for (int m = 0; m < NM; m++) chk_master(m, (m + k) % NSL);
      chk(s_rready == used && s_bready == used, "R11 concurrent ready steering",
          {s_rready, s_bready}, {used, used});
      @(posedge clk); #1;
      chk(rd_end == used && wr_end == used, "R11 concurrent end pulses",
          {rd_end, wr_end}, {used, used});
    end

    @(negedge clk);
    slv_grant = '0; s_rvalid = '0; s_bvalid = '0;
    #1;
    for (int m = 0; m < NM; m++) chk_master(m, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule